// File: doc/BRIEF.md
# Interrupt Context Register Window for a Multi-Channel Serial Controller

This block gives a host one fixed register window for servicing an eight-channel serial controller. Each channel can raise three kinds of request: a receive request (optionally flagged with receive errors), a transmit request, and a miscellaneous event carried as a three-bit code. When the host pulses `ack`, the block picks the lowest-numbered channel that has any request. It latches that channel's number and an encoded interrupt type byte into a context register. The context then stays put until the next acknowledge.

Through the window the host reads four things: the latched channel, a live byte-count code for that channel, the type byte, and a FIFO port. A read of the FIFO port pops the latched channel's receive FIFO. A write to the FIFO port pushes into its transmit FIFO. Data is masked to the channel's configured character length. The FIFOs, the serial engines and the arbitration policy beyond a lowest-index pick live outside the block.

The context is held by a four-state machine:
- `CTX_NONE`: no valid context.
- `CTX_RX`: a receive request was picked.
- `CTX_TX`: a transmit request was picked, with no receive request.
- `CTX_EVT`: only an event was picked.

Every state takes the same single transition, ACK_CAPTURE, on `ack`. The next state comes from the request kinds of the picked channel, with priority receive, then transmit, then event. With no request anywhere the next state is `CTX_NONE`. Without `ack`, every state holds.

Top module: `gia_global_port`

## Requirements
- R1: On `ack`, the channel captured is the lowest index with `rx_req`, `tx_req` or a valid event code. A read of address 0 returns {bit7 = context valid, bits 6:3 = 0, bits 2:0 = channel}.
- R2: Channel, type and state change only on `ack`. Between acknowledges they stay unchanged even if the request inputs change.
- R3: An `ack` with no request anywhere captures type 0x00 and marks the context invalid, so address 0 reads 0x00.
- R4: Type byte (address 2) bits 7:6 are 00 when the picked channel has no receive request. They are 10 for a receive request with `rx_err` set, and 11 for a receive request without it.
- R5: Type bit 5 is 1 exactly when the picked channel has a transmit request. Type bits 4:3 always read 00.
- R6: Type bits 2:0 carry the picked channel's event code when it is 001, 010, 011 or 101. Any other code (100, 11x) is not a request and is captured as 000.
- R7: Address 1 reads {0000, code}, where code is the live level of the latched channel minus one. In `CTX_RX` the level is `rx_level`; in `CTX_TX` it is `tx_free`. A level of 0 gives 0, a level above 16 gives 15, and any other state gives 0.
- R8: In `CTX_RX`, a read of address 3 pulses `rx_pop` one-hot on the latched channel during the read cycle. It returns the head byte masked to the character length (`char_len` 00=5, 01=6, 10=7, 11=8 bits).
- R9: A read of address 3 outside `CTX_RX` returns 0x00 and pops no FIFO.
- R10: A write to address 3 with a valid context pulses `tx_push` one-hot on the latched channel, in any valid state. `tx_data` is `wdata` masked to that channel's character length. With no valid context, nothing is pushed.
- R11: `rdata` is registered. It updates on the clock edge that samples `rd_en` and holds otherwise. Reset clears `rdata` and the context.
- R12: `irq` is high whenever any channel has a receive, transmit or valid event request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack | input | 1 | Capture interrupt context strobe |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Window address: 0 channel, 1 count, 2 type, 3 FIFO |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| irq | output | 1 | Any channel requesting |
| rx_req | input | NCH | Per-channel receive request |
| rx_err | input | NCH | Per-channel receive error flag |
| tx_req | input | NCH | Per-channel transmit request |
| evt_code | input | 3*NCH | Per-channel event code |
| rx_level | input | 5*NCH | Per-channel receive FIFO fill level |
| tx_free | input | 5*NCH | Per-channel transmit FIFO free space |
| char_len | input | 2*NCH | Per-channel character length setting |
| rx_head | input | 8*NCH | Per-channel receive FIFO head byte |
| rx_pop | output | NCH | One-hot receive FIFO pop |
| tx_push | output | NCH | One-hot transmit FIFO push |
| tx_data | output | 8 | Masked transmit data |

## Verification
The assertions assume that `ack`, `rd_en` and `wr_en` are single-cycle host strobes sampled on the clock. They also assume that request, level and head inputs are steady across the edge where they are used. The bench drives every input on the falling edge and holds it through the next rising edge. It never issues a read and a write in the same cycle, and it changes request inputs between acknowledges only to show that the latched context ignores them.

// File: rtl/gia_pkg.sv
package gia_pkg;

    typedef enum logic [1:0] {
        CTX_NONE = 2'd0,
        CTX_RX   = 2'd1,
        CTX_TX   = 2'd2,
        CTX_EVT  = 2'd3
    } ctx_state_e;

    localparam logic [1:0] ADR_CHAN  = 2'd0;
    localparam logic [1:0] ADR_COUNT = 2'd1;
    localparam logic [1:0] ADR_TYPE  = 2'd2;
    localparam logic [1:0] ADR_FIFO  = 2'd3;

    localparam logic [2:0] EVT_COS  = 3'b001;
    localparam logic [2:0] EVT_ADDR = 3'b010;
    localparam logic [2:0] EVT_FLOW = 3'b011;
    localparam logic [2:0] EVT_BRK  = 3'b101;

    function automatic logic evt_code_ok(input logic [2:0] c);
        return (c == EVT_COS) || (c == EVT_ADDR) || (c == EVT_FLOW) || (c == EVT_BRK);
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] l);
        logic [7:0] m;
        case (l)
            2'b00:   m = 8'h1F;
            2'b01:   m = 8'h3F;
            2'b10:   m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gia_pick.sv
module gia_pick #(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] pick
);

    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) pick = CHW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/gia_ctx_fsm.sv
module gia_ctx_fsm
    import gia_pkg::*;
#(
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ack,
    input  logic           any,
    input  logic [CHW-1:0] pick,
    input  logic           sel_rx,
    input  logic           sel_err,
    input  logic           sel_tx,
    input  logic [2:0]     sel_evt,
    output ctx_state_e     state,
    output logic [CHW-1:0] ctx_ch,
    output logic [7:0]     ctx_type
);

    ctx_state_e nxt;
    ctx_state_e pick_kind;
    logic [7:0] type_new;

    always_comb begin
        if (!any)        pick_kind = CTX_NONE;
        else if (sel_rx) pick_kind = CTX_RX;
        else if (sel_tx) pick_kind = CTX_TX;
        else             pick_kind = CTX_EVT;
    end

    always_comb begin
        type_new = 8'h00;
        if (any) begin
            type_new[7:6] = sel_rx ? {1'b1, ~sel_err} : 2'b00;
            type_new[5]   = sel_tx;
            type_new[2:0] = evt_code_ok(sel_evt) ? sel_evt : 3'b000;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CTX_NONE: if (ack) nxt = pick_kind;
            CTX_RX:   if (ack) nxt = pick_kind;
            CTX_TX:   if (ack) nxt = pick_kind;
            CTX_EVT:  if (ack) nxt = pick_kind;
            default:  nxt = CTX_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CTX_NONE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_ch   <= '0;
            ctx_type <= 8'h00;
        end else if (ack) begin
            ctx_ch   <= any ? pick : '0;
            ctx_type <= type_new;
        end
    end

    // R2
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> ($stable(ctx_ch) && $stable(ctx_type) && $stable(state)));

    // R3
    none_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTX_NONE) |-> (ctx_type == 8'h00 && ctx_ch == '0));

    // R5
    type_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_type[4:3] == 2'b00);

endmodule

// File: rtl/gia_regmux.sv
module gia_regmux
    import gia_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int CHW        = $clog2(NCH),
    parameter int FIFO_DEPTH = 16,
    parameter int LVLW       = $clog2(FIFO_DEPTH + 1),
    parameter int CNTW       = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctx_state_e        state,
    input  logic [CHW-1:0]    ctx_ch,
    input  logic [7:0]        ctx_type,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  logic [NCH*LVLW-1:0] rx_level,
    input  logic [NCH*LVLW-1:0] tx_free,
    input  logic [NCH*2-1:0]  char_len,
    input  logic [NCH*8-1:0]  rx_head,
    output logic [7:0]        rdata,
    output logic [NCH-1:0]    rx_pop,
    output logic [NCH-1:0]    tx_push,
    output logic [7:0]        tx_data
);

    logic [LVLW-1:0] lvl;
    logic [CNTW-1:0] cnt;
    logic [7:0]      mask;
    logic [7:0]      head;
    logic [7:0]      rd_next;
    logic [NCH-1:0]  ch_hot;
    logic            valid;

    assign valid  = (state != CTX_NONE);
    assign mask   = len_mask(char_len[ctx_ch*2 +: 2]);
    assign head   = rx_head[ctx_ch*8 +: 8] & mask;
    assign ch_hot = NCH'(1) << ctx_ch;

    always_comb begin
        unique case (state)
            CTX_RX:  lvl = rx_level[ctx_ch*LVLW +: LVLW];
            CTX_TX:  lvl = tx_free[ctx_ch*LVLW +: LVLW];
            default: lvl = '0;
        endcase
        if (lvl == '0)                          cnt = '0;
        else if (lvl > LVLW'(FIFO_DEPTH))       cnt = '1;
        else                                    cnt = CNTW'(lvl - LVLW'(1));
    end

    always_comb begin
        unique case (addr)
            ADR_CHAN:  rd_next = {valid, {(7-CHW){1'b0}}, ctx_ch};
            ADR_COUNT: rd_next = {{(8-CNTW){1'b0}}, cnt};
            ADR_TYPE:  rd_next = ctx_type;
            default:   rd_next = (state == CTX_RX) ? head : 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_next;
    end

    assign rx_pop  = (rd_en && addr == ADR_FIFO && state == CTX_RX) ? ch_hot : '0;
    assign tx_push = (wr_en && addr == ADR_FIFO && valid) ? ch_hot : '0;
    assign tx_data = wdata & mask;

    // R8
    pop_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pop));

    // R9
    no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CTX_RX) |-> (rx_pop == '0));

    // R10
    push_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTX_NONE) |-> (tx_push == '0));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/gia_global_port.sv
module gia_global_port
    import gia_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int CHW        = $clog2(NCH),
    parameter int LVLW       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic                irq,
    input  logic [NCH-1:0]      rx_req,
    input  logic [NCH-1:0]      rx_err,
    input  logic [NCH-1:0]      tx_req,
    input  logic [NCH*3-1:0]    evt_code,
    input  logic [NCH*LVLW-1:0] rx_level,
    input  logic [NCH*LVLW-1:0] tx_free,
    input  logic [NCH*2-1:0]    char_len,
    input  logic [NCH*8-1:0]    rx_head,
    output logic [NCH-1:0]      rx_pop,
    output logic [NCH-1:0]      tx_push,
    output logic [7:0]          tx_data
);

    logic [NCH-1:0] evt_ok;
    logic [NCH-1:0] req_all;
    logic           any;
    logic [CHW-1:0] pick;
    ctx_state_e     state;
    logic [CHW-1:0] ctx_ch;
    logic [7:0]     ctx_type;

    for (genvar g = 0; g < NCH; g++) begin : g_evt
        assign evt_ok[g] = evt_code_ok(evt_code[g*3 +: 3]);
    end

    assign req_all = rx_req | tx_req | evt_ok;
    assign irq     = any;

    gia_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .req  (req_all),
        .any  (any),
        .pick (pick)
    );

    gia_ctx_fsm #(.CHW(CHW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack      (ack),
        .any      (any),
        .pick     (pick),
        .sel_rx   (rx_req[pick]),
        .sel_err  (rx_err[pick]),
        .sel_tx   (tx_req[pick]),
        .sel_evt  (evt_code[pick*3 +: 3]),
        .state    (state),
        .ctx_ch   (ctx_ch),
        .ctx_type (ctx_type)
    );

    gia_regmux #(.NCH(NCH), .CHW(CHW), .FIFO_DEPTH(FIFO_DEPTH), .LVLW(LVLW)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .ctx_ch   (ctx_ch),
        .ctx_type (ctx_type),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rx_level (rx_level),
        .tx_free  (tx_free),
        .char_len (char_len),
        .rx_head  (rx_head),
        .rdata    (rdata),
        .rx_pop   (rx_pop),
        .tx_push  (tx_push),
        .tx_data  (tx_data)
    );

    // R1
    pick_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req_all[pick]);

    // R1
    pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ((req_all & ((NCH'(1) << pick) - NCH'(1))) == '0));

endmodule

// File: tb/test_gia_global_port.sv
module test_gia_global_port;

    localparam int NCH = 8;
    localparam int LVLW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic irq;
    logic [NCH-1:0] rx_req = '0, rx_err = '0, tx_req = '0;
    logic [NCH*3-1:0] evt_code = '0;
    logic [NCH*LVLW-1:0] rx_level, tx_free;
    logic [NCH*2-1:0] char_len;
    logic [NCH*8-1:0] rx_head;
    logic [NCH-1:0] rx_pop, tx_push;
    logic [7:0] tx_data;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gia_global_port i_gia_global_port (
        .clk(clk), .rst_n(rst_n), .ack(ack), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
        .rx_req(rx_req), .rx_err(rx_err), .tx_req(tx_req), .evt_code(evt_code),
        .rx_level(rx_level), .tx_free(tx_free), .char_len(char_len),
        .rx_head(rx_head), .rx_pop(rx_pop), .tx_push(tx_push), .tx_data(tx_data)
    );

    // {rx_req, rx_err, tx_req, evt_code, chan, type, count}
    localparam logic [71:0] VEC [8] = '{
        {8'h04, 8'h00, 8'h00, 24'h000000, 8'h82, 8'hC0, 8'h04},
        {8'h10, 8'h10, 8'h08, 24'h000000, 8'h83, 8'h20, 8'h05},
        {8'h20, 8'h20, 8'h20, 24'h000000, 8'h85, 8'hA0, 8'h07},
        {8'h40, 8'h00, 8'h00, 24'h000008, 8'h81, 8'h01, 8'h00},
        {8'h00, 8'h00, 8'h01, 24'h000005, 8'h80, 8'h25, 8'h00},
        {8'h00, 8'h00, 8'h00, 24'h003004, 8'h84, 8'h03, 8'h00},
        {8'h00, 8'h00, 8'h00, 24'h000000, 8'h00, 8'h00, 8'h00},
        {8'h80, 8'h00, 8'h00, 24'h400000, 8'h87, 8'hC2, 8'h09}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic set_vec(input int k);
        {rx_req, rx_err, tx_req, evt_code} = VEC[k][71:24];
    endtask

    task automatic do_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] v, output logic [NCH-1:0] pop);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 pop = rx_pop;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic do_write(input logic [7:0] d, output logic [NCH-1:0] push, output logic [7:0] td);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd3; wdata = d;
        #2 push = tx_push; td = tx_data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL R11 watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [NCH-1:0] p;
        logic [7:0] td;
        for (int i = 0; i < NCH; i++) begin
            rx_level[i*LVLW +: LVLW] = LVLW'(i + 3);
            tx_free[i*LVLW +: LVLW]  = LVLW'(2 * i);
            char_len[i*2 +: 2]       = 2'(i % 4);
            rx_head[i*8 +: 8]        = 8'hF0 | 8'(i);
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset rdata", rdata, 8'h00);
        chk("R12 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        do_read(2'd0, v, p);
        chk("R3 reset chan", v, 8'h00);

        for (int k = 0; k < 8; k++) begin
            set_vec(k);
            #1 chk("R12 irq", {7'b0, irq}, {7'b0, VEC[k][23]});
            do_ack();
            do_read(2'd0, v, p);
            chk("R1 chan", v, VEC[k][23:16]);
            do_read(2'd2, v, p);
            chk("R4 R5 R6 type", v, VEC[k][15:8]);
            do_read(2'd1, v, p);
            chk("R7 count", v, VEC[k][7:0]);
        end

        // R8: rx context on ch2, 7-bit chars
        set_vec(0); do_ack();
        do_read(2'd3, v, p);
        chk("R8 fifo data", v, 8'h72);
        chk("R8 pop", p, 8'h04);
        // R2: inputs change, context held
        rx_req = 8'h01; tx_req = 8'h01;
        repeat (2) @(negedge clk);
        do_read(2'd0, v, p);
        chk("R2 chan held", v, 8'h82);
        do_read(2'd2, v, p);
        chk("R2 type held", v, 8'hC0);
        // R7 live level and clamps
        rx_level[2*LVLW +: LVLW] = 5'd20;
        do_read(2'd1, v, p);
        chk("R7 clamp high", v, 8'h0F);
        rx_level[2*LVLW +: LVLW] = 5'd0;
        do_read(2'd1, v, p);
        chk("R7 zero level", v, 8'h00);
        rx_level[2*LVLW +: LVLW] = 5'd5;

        // R9: tx context on ch3
        set_vec(1); do_ack();
        do_read(2'd3, v, p);
        chk("R9 fifo data", v, 8'h00);
        chk("R9 pop", p, 8'h00);
        // R10: push on ch3, 8-bit
        do_write(8'hAB, p, td);
        chk("R10 push", p, 8'h08);
        chk("R10 data", td, 8'hAB);
        // R10: rx context ch5, 6-bit chars, write still lands
        set_vec(2); do_ack();
        do_write(8'hFF, p, td);
        chk("R10 push rx ctx", p, 8'h20);
        chk("R10 data mask", td, 8'h3F);

        // R3: no requests
        set_vec(6); do_ack();
        do_write(8'h55, p, td);
        chk("R3 no push", p, 8'h00);
        do_read(2'd2, v, p);
        chk("R3 type", v, 8'h00);
        do_read(2'd0, v, p);
        chk("R3 chan", v, 8'h00);
        // R11 hold without read
        repeat (4) @(negedge clk);
        chk("R11 hold", rdata, 8'h00);
        set_vec(7); do_ack();
        do_read(2'd0, v, p);
        repeat (3) @(negedge clk);
        chk("R11 hold after read", rdata, 8'h87);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule